// File: doc/BRIEF.md
# USB Bus-State and Endpoint Event Register Bank

This block sits between a USB serial interface engine and a microcontroller's byte-wide register bus. It holds two registers. The bus-state register mixes flags that only the engine can change (suspend, bus reset, resume) with control bits that only firmware can change (remote-wakeup command, regulator enable, reset routing). The endpoint register holds one sticky access flag for each endpoint. The engine marks a flag on each access, and firmware clears it after servicing.

A small link-state machine follows suspend and resume. It has three states. `LINK_ACTIVE` is the normal bus state. `LINK_SUSPENDED` is entered when the engine reports suspend. `LINK_RESUMED` is entered from `LINK_SUSPENDED` when the engine reports resume activity while suspend is still asserted. The machine has five transitions:
- `ACTIVE->SUSPENDED` when suspend goes high.
- `SUSPENDED->RESUMED` on a resume report.
- `SUSPENDED->ACTIVE` when suspend drops without a resume report.
- `RESUMED->ACTIVE` when suspend drops.
- Every other case holds the current state.

The block drives three requests. The USB interrupt is a one-cycle pulse, and qualifying events that fall in the same cycle give one pulse. The wake-up request is a one-cycle pulse. The MCU reset request is the bus reset flag gated by the reset-routing bit.

Top module: `usb_evt_regs`

## Requirements
- R1: After reset, the bus-state register (address 0) reads 0x80 and the endpoint register (address 1) reads 0x00. `usb_irq`, `wake_req`, `rmt_wake`, `reg_en` and `mcu_rst_req` are all low.
- R2: Bus-state bit 0 (suspend) is read-only. It is set on the clock edge that samples `sie_suspend` high and cleared on the edge that samples it low. Its rise gives a `usb_irq` pulse in the following cycle.
- R3: Bus-state bit 2 (bus reset) is read-only and equals `sie_bus_reset` as sampled at the last edge. Its rise gives a `usb_irq` pulse.
- R4: Bus-state bit 3 (resume) is set when `sie_resume` is sampled high while the link is suspended. That edge also gives a one-cycle `wake_req` pulse. A resume report while the link is not suspended changes nothing.
- R5: The resume bit returns to 0 on the edge that samples `sie_suspend` low.
- R6: Bus-state bit 1 is a firmware read/write bit that resets to 0 and drives `rmt_wake`.
- R7: Bus-state bit 4 is a firmware read/write bit that resets to 0 and drives `reg_en`. A value of 1 means the regulator is on.
- R8: Bus-state bit 7 is a firmware read/write bit that resets to 1. `mcu_rst_req` is high exactly when both the bus reset bit and bit 7 are 1.
- R9: Bus-state bits 5 and 6 and endpoint-register bits 5 to 7 always read 0, and writes to them are ignored.
- R10: Endpoint bit n (0 to 4) is set when `sie_ep_hit[n]` is sampled high. It stays set until a write to address 1 carries 0 in bit n. Writing 1 leaves the bit unchanged.
- R11: If an endpoint hit and a firmware clear of the same bit fall on the same edge, the bit ends up set.
- R12: `usb_irq` pulses only when `irq_en` is high and `stack_full` is low at the event edge. Events that fall on the same edge give a single one-cycle pulse.
- R13: `bus_rdata` follows `bus_addr` combinationally. Any other address reads 0. Writes take effect on the edge where `bus_we` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sie_suspend | input | 1 | Engine reports that the bus is suspended (level) |
| sie_resume | input | 1 | Engine reports resume activity (pulse) |
| sie_bus_reset | input | 1 | Engine reports a bus reset (level) |
| sie_ep_hit | input | NUM_EP | Per-endpoint access strobes |
| irq_en | input | 1 | USB interrupt enable |
| stack_full | input | 1 | Interrupt stack full; blocks new requests |
| bus_addr | input | ADDR_W | Register address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational) |
| usb_irq | output | 1 | USB interrupt request pulse |
| wake_req | output | 1 | MCU wake-up request pulse |
| rmt_wake | output | 1 | Remote-wakeup command to the bus logic |
| reg_en | output | 1 | Regulator output enable |
| mcu_rst_req | output | 1 | Gated MCU reset request |

## Verification
Two cases of same-cycle collision get directed tests.

The first is an endpoint hit landing on the same edge as a firmware write of 0 to that endpoint's bit. The bench sets two flags, then writes 0x00 while bit 1 is hit again. It expects bit 1 to survive and bit 0 to clear.

The second is a suspend rise coinciding with an endpoint access. The bench expects `usb_irq` high for exactly one cycle and low in the next.

// File: rtl/usbsr_pkg.sv
package usbsr_pkg;
    localparam int BYTE_W    = 8;
    localparam int STAT_ADDR = 0;
    localparam int EP_ADDR   = 1;

    // bus-state register bit positions (firmware decodes these)
    localparam int B_SUSP  = 0;
    localparam int B_RWAKE = 1;
    localparam int B_BRST  = 2;
    localparam int B_RESUM = 3;
    localparam int B_REGEN = 4;
    localparam int B_ROUTE = 7;

    typedef enum logic [1:0] {
        LINK_ACTIVE    = 2'd0,
        LINK_SUSPENDED = 2'd1,
        LINK_RESUMED   = 2'd2
    } link_state_e;
endpackage

// File: rtl/usbsr_link_fsm.sv
module usbsr_link_fsm
    import usbsr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sie_suspend,
    input  logic sie_resume,
    input  logic sie_bus_reset,
    output logic susp_flag,
    output logic resume_flag,
    output logic brst_flag,
    output logic susp_rise,
    output logic resume_rise,
    output logic brst_rise
);
    link_state_e state_q, state_d;
    logic        brst_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= LINK_ACTIVE;
            brst_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            brst_q  <= sie_bus_reset;
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LINK_ACTIVE:
                if (sie_suspend) state_d = LINK_SUSPENDED;
            LINK_SUSPENDED:
                if (!sie_suspend)    state_d = LINK_ACTIVE;
                else if (sie_resume) state_d = LINK_RESUMED;
            LINK_RESUMED:
                if (!sie_suspend) state_d = LINK_ACTIVE;
            default: state_d = LINK_ACTIVE;
        endcase
    end

    // outputs
    always_comb begin
        susp_flag   = (state_q != LINK_ACTIVE);
        resume_flag = (state_q == LINK_RESUMED);
        brst_flag   = brst_q;
        susp_rise   = (state_q == LINK_ACTIVE) && sie_suspend;
        resume_rise = (state_q == LINK_SUSPENDED) && sie_suspend && sie_resume;
        brst_rise   = sie_bus_reset && !brst_q;
    end
endmodule

// File: rtl/usbsr_ctrl_bits.sv
module usbsr_ctrl_bits
    import usbsr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stat,
    input  logic [BYTE_W-1:0] wdata,
    output logic              rwake_q,
    output logic              regen_q,
    output logic              route_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rwake_q <= 1'b0;
            regen_q <= 1'b0;
            route_q <= 1'b1;
        end else if (wr_stat) begin
            rwake_q <= wdata[B_RWAKE];
            regen_q <= wdata[B_REGEN];
            route_q <= wdata[B_ROUTE];
        end
    end
endmodule

// File: rtl/usbsr_ep_flags.sv
module usbsr_ep_flags #(
    parameter int NUM_EP = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_EP-1:0] hit,
    input  logic              wr_ep,
    input  logic [NUM_EP-1:0] wbits,
    output logic [NUM_EP-1:0] flags
);
    for (genvar g = 0; g < NUM_EP; g++) begin : g_flag
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                 flags[g] <= 1'b0;
            else if (hit[g])            flags[g] <= 1'b1;   // set beats clear
            else if (wr_ep && !wbits[g]) flags[g] <= 1'b0;
        end
    end
endmodule

// File: rtl/usbsr_irq_merge.sv
module usbsr_irq_merge (
    input  logic clk,
    input  logic rst_n,
    input  logic susp_rise,
    input  logic brst_rise,
    input  logic ep_any,
    input  logic resume_rise,
    input  logic irq_en,
    input  logic stack_full,
    output logic usb_irq,
    output logic wake_req
);
    logic irq_ev;
    assign irq_ev = (susp_rise || brst_rise || ep_any) && irq_en && !stack_full;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            usb_irq  <= 1'b0;
            wake_req <= 1'b0;
        end else begin
            usb_irq  <= irq_ev;
            wake_req <= resume_rise;
        end
    end
endmodule

// File: rtl/usb_evt_regs.sv
module usb_evt_regs
    import usbsr_pkg::*;
#(
    parameter int NUM_EP = 5,
    parameter int ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sie_suspend,
    input  logic              sie_resume,
    input  logic              sie_bus_reset,
    input  logic [NUM_EP-1:0] sie_ep_hit,
    input  logic              irq_en,
    input  logic              stack_full,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    output logic              usb_irq,
    output logic              wake_req,
    output logic              rmt_wake,
    output logic              reg_en,
    output logic              mcu_rst_req
);
    localparam int EP_PAD = BYTE_W - NUM_EP;

    logic sel_stat, sel_ep;
    logic susp_flag, resume_flag, brst_flag;
    logic susp_rise, resume_rise, brst_rise;
    logic rwake_q, regen_q, route_q;
    logic [NUM_EP-1:0] ep_flags;
    logic [BYTE_W-1:0] stat_byte, ep_byte;

    assign sel_stat = (bus_addr == ADDR_W'(STAT_ADDR));
    assign sel_ep   = (bus_addr == ADDR_W'(EP_ADDR));

    usbsr_link_fsm u_link (
        .clk(clk), .rst_n(rst_n),
        .sie_suspend(sie_suspend), .sie_resume(sie_resume),
        .sie_bus_reset(sie_bus_reset),
        .susp_flag(susp_flag), .resume_flag(resume_flag), .brst_flag(brst_flag),
        .susp_rise(susp_rise), .resume_rise(resume_rise), .brst_rise(brst_rise)
    );

    usbsr_ctrl_bits u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .wr_stat(bus_we && sel_stat), .wdata(bus_wdata),
        .rwake_q(rwake_q), .regen_q(regen_q), .route_q(route_q)
    );

    usbsr_ep_flags #(.NUM_EP(NUM_EP)) u_ep (
        .clk(clk), .rst_n(rst_n),
        .hit(sie_ep_hit), .wr_ep(bus_we && sel_ep),
        .wbits(bus_wdata[NUM_EP-1:0]), .flags(ep_flags)
    );

    usbsr_irq_merge u_irq (
        .clk(clk), .rst_n(rst_n),
        .susp_rise(susp_rise), .brst_rise(brst_rise), .ep_any(|sie_ep_hit),
        .resume_rise(resume_rise), .irq_en(irq_en), .stack_full(stack_full),
        .usb_irq(usb_irq), .wake_req(wake_req)
    );

    always_comb begin
        stat_byte         = '0;
        stat_byte[B_SUSP]  = susp_flag;
        stat_byte[B_RWAKE] = rwake_q;
        stat_byte[B_BRST]  = brst_flag;
        stat_byte[B_RESUM] = resume_flag;
        stat_byte[B_REGEN] = regen_q;
        stat_byte[B_ROUTE] = route_q;
        ep_byte            = {{EP_PAD{1'b0}}, ep_flags};
    end

    assign bus_rdata   = sel_stat ? stat_byte : (sel_ep ? ep_byte : '0);
    assign rmt_wake    = rwake_q;
    assign reg_en      = regen_q;
    assign mcu_rst_req = brst_flag && route_q;
endmodule

// File: rtl/usb_evt_regs_chk.sv
module usb_evt_regs_chk #(
    parameter int NUM_EP = 5,
    parameter int ADDR_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sie_suspend,
    input logic              sie_bus_reset,
    input logic [NUM_EP-1:0] sie_ep_hit,
    input logic              irq_en,
    input logic              stack_full,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_we,
    input logic              usb_irq,
    input logic              wake_req,
    input logic              mcu_rst_req,
    input logic              resume_flag,
    input logic              route_q,
    input logic [NUM_EP-1:0] ep_flags
);
    // R12
    assert_irq_gated_R12: assert property (@(posedge clk) disable iff (!rst_n)
        usb_irq |-> $past(irq_en && !stack_full));

    // R5
    assert_resume_cleared_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !sie_suspend |=> !resume_flag);

    // R4
    assert_wake_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wake_req |=> !wake_req);

    // R8
    assert_rst_routed_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (sie_bus_reset && route_q && !(bus_we && bus_addr == ADDR_W'(0)))
        |=> mcu_rst_req);

    // R10
    assert_ep_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (ep_flags[0] && !(bus_we && bus_addr == ADDR_W'(1))) |=> ep_flags[0]);

    // R11
    assert_set_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
        sie_ep_hit[0] |=> ep_flags[0]);
endmodule

bind usb_evt_regs usb_evt_regs_chk #(.NUM_EP(NUM_EP), .ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .sie_suspend(sie_suspend),
    .sie_bus_reset(sie_bus_reset), .sie_ep_hit(sie_ep_hit),
    .irq_en(irq_en), .stack_full(stack_full), .bus_addr(bus_addr),
    .bus_we(bus_we), .usb_irq(usb_irq), .wake_req(wake_req),
    .mcu_rst_req(mcu_rst_req), .resume_flag(resume_flag),
    .route_q(route_q), .ep_flags(ep_flags)
);

// File: tb/usb_evt_regs_test.sv
module usb_evt_regs_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sie_suspend = 0, sie_resume = 0, sie_bus_reset = 0;
    logic [4:0] sie_ep_hit = '0;
    logic       irq_en = 0, stack_full = 0;
    logic [1:0] bus_addr = '0;
    logic       bus_we = 0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       usb_irq, wake_req, rmt_wake, reg_en, mcu_rst_req;
    int         n_chk = 0, n_bad = 0;
    bit         done = 0;

    always #5 clk = ~clk;

    usb_evt_regs uut (
        .clk(clk), .rst_n(rst_n), .sie_suspend(sie_suspend), .sie_resume(sie_resume),
        .sie_bus_reset(sie_bus_reset), .sie_ep_hit(sie_ep_hit), .irq_en(irq_en),
        .stack_full(stack_full), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .usb_irq(usb_irq),
        .wake_req(wake_req), .rmt_wake(rmt_wake), .reg_en(reg_en),
        .mcu_rst_req(mcu_rst_req)
    );

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    // one clock edge; inputs were set away from the edge, sample 1 ns after it
    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic rd(logic [1:0] a, string req, logic [7:0] exp);
        bus_addr = a;
        #1;
        chk(req, bus_rdata, exp);
    endtask

    task automatic wr(logic [1:0] a, logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_we = 1;
        step();
        bus_we = 0;
    endtask

    task automatic t_reset();
        rd(0, "R1 stat", 8'h80);
        rd(1, "R1 ep", 8'h00);
        chk("R1 outs", {3'b0, usb_irq, wake_req, rmt_wake, reg_en, mcu_rst_req}, 8'h00);
    endtask

    task automatic t_ctrl();
        wr(0, 8'hFF);
        rd(0, "R9 stat bits5-6", 8'h92);
        chk("R6 rmt_wake", {7'b0, rmt_wake}, 8'h01);
        chk("R7 reg_en", {7'b0, reg_en}, 8'h01);
        wr(0, 8'h00);
        rd(0, "R6 R7 R8 clear", 8'h00);
        chk("R7 reg_en off", {7'b0, reg_en}, 8'h00);
        wr(0, 8'h80);
        rd(2, "R13 unmapped", 8'h00);
    endtask

    task automatic t_bus_reset();
        irq_en = 1;
        sie_bus_reset = 1;
        step();
        chk("R3 irq", {7'b0, usb_irq}, 8'h01);
        rd(0, "R3 flag", 8'h84);
        chk("R8 routed", {7'b0, mcu_rst_req}, 8'h01);
        step();
        chk("R3 irq one cycle", {7'b0, usb_irq}, 8'h00);
        wr(0, 8'h00);
        chk("R8 blocked", {7'b0, mcu_rst_req}, 8'h00);
        sie_bus_reset = 0;
        step();
        rd(0, "R3 released", 8'h00);
        wr(0, 8'h80);
    endtask

    task automatic t_suspend();
        sie_resume = 1;            // not suspended: ignored
        step();
        sie_resume = 0;
        chk("R4 ignored wake", {7'b0, wake_req}, 8'h00);
        rd(0, "R4 ignored flag", 8'h80);
        sie_suspend = 1;
        step();
        chk("R2 irq", {7'b0, usb_irq}, 8'h01);
        rd(0, "R2 flag", 8'h81);
        step();
        chk("R2 irq one cycle", {7'b0, usb_irq}, 8'h00);
        sie_resume = 1;
        step();
        sie_resume = 0;
        chk("R4 wake", {7'b0, wake_req}, 8'h01);
        rd(0, "R4 flag", 8'h89);
        step();
        chk("R4 wake one cycle", {7'b0, wake_req}, 8'h00);
        sie_suspend = 0;
        step();
        rd(0, "R5 auto clear", 8'h80);
    endtask

    task automatic t_endpoints();
        sie_ep_hit = 5'b01010;
        step();
        sie_ep_hit = '0;
        chk("R10 irq", {7'b0, usb_irq}, 8'h01);
        rd(1, "R10 set", 8'h0A);
        wr(1, 8'hFF);
        rd(1, "R10 R9 write ones", 8'h0A);
        wr(1, 8'hF7);
        rd(1, "R10 clear bit3", 8'h02);
        sie_ep_hit = 5'b00001;
        step();
        sie_ep_hit = 5'b00010;
        wr(1, 8'h00);
        sie_ep_hit = '0;
        rd(1, "R11 set wins", 8'h02);
        wr(1, 8'h00);
        rd(1, "R10 cleared", 8'h00);
    endtask

    task automatic t_gating();
        irq_en = 0;
        sie_ep_hit = 5'b10000;
        step();
        sie_ep_hit = '0;
        chk("R12 disabled", {7'b0, usb_irq}, 8'h00);
        rd(1, "R12 flag still set", 8'h10);
        irq_en = 1; stack_full = 1;
        sie_ep_hit = 5'b00100;
        step();
        sie_ep_hit = '0;
        chk("R12 stack full", {7'b0, usb_irq}, 8'h00);
        stack_full = 0;
        sie_suspend = 1; sie_ep_hit = 5'b00001;
        step();
        sie_ep_hit = '0;
        chk("R12 merged pulse", {7'b0, usb_irq}, 8'h01);
        step();
        chk("R12 merged ends", {7'b0, usb_irq}, 8'h00);
        sie_suspend = 0;
        step();
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        #23;
        rst_n = 1;
        #2;
        t_reset();
        t_ctrl();
        t_bus_reset();
        t_suspend();
        t_endpoints();
        t_gating();
        summary();
    end

    initial begin
        #1000000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end
endmodule